// File: doc/BRIEF.md
# Four-Way Pin Function Multiplexer

This block decides, for each pin of a 32-pin I/O bank, who drives the pad. A pin can be owned by the general-purpose I/O logic. Otherwise it is handed to one of four peripheral ports, named A, B, C and D. Software picks the peripheral with a 2-bit function code per pin. The low bits of all codes live in one read/write register and the high bits in a second one. To move a single pin, software reads a select register, changes one bit and writes the result back, so no other pin is disturbed.

The same register file holds the pad-control state for each pin: pull-up, pull-down and Schmitt-trigger disable. These are driven straight out on per-pin control lines. Ownership, direction, output data and both pulls use register triplets: a set register, a clear register and a status register. A 1 written to a bit acts on that pin only.

The bus is a simple register port with a write strobe and a read strobe. It is always ready and applies no back-pressure: a write takes effect at the clock edge, and a read returns its data one cycle later with a valid flag. The peripheral output and output-enable lines reach the pads through combinational logic only.

Top module: `pinmux_bank`

## Requirements
- R1: After reset every pin is owned by general-purpose I/O (ownership status reads all ones). Both select registers, the pull-down status, the Schmitt register, the direction status and the output data status read 0. The pull-up status reads all ones, and pad_oe and pad_out are 0.
- R2: A write to offset 0x00 gives each pin whose bit is 1 to general-purpose I/O. A write to 0x04 hands each such pin to its selected peripheral. Offset 0x08 reads ownership, where 1 means general-purpose I/O.
- R3: The select registers at 0x70 (low code bit) and 0x74 (high code bit) are plain read/write: a write replaces the whole register and a read returns it unchanged.
- R4: For a pin owned by a peripheral, the code {bit of 0x74, bit of 0x70} selects the source: 0 is port A, 1 is port B, 2 is port C and 3 is port D. pad_out and pad_oe follow that port's output and output-enable bits in the same cycle.
- R5: For a pin owned by general-purpose I/O, pad_out and pad_oe come from the output data and direction registers, whatever the select code is.
- R6: The direction registers are at 0x10 (set: output), 0x14 (clear) and 0x18 (status). The output data registers are at 0x30 (set), 0x34 (clear) and 0x38 (status).
- R7: The pull-up registers are at 0x60 (disable), 0x64 (enable) and 0x68 (status), and pad_pu follows the status.
- R8: The pull-down registers are at 0x90 (disable), 0x94 (enable) and 0x98 (status), and pad_pd follows the status.
- R9: Enabling pull-down on a pin clears that pin's pull-up, and enabling pull-up clears its pull-down. pad_pu and pad_pd are never both 1 on the same pin.
- R10: Offset 0x100 is read/write. pad_schmitt_dis follows it: a 1 disables that pin's Schmitt trigger.
- R11: bus_rvalid is 1 exactly in the cycle after bus_rd is asserted. bus_rdata then holds the register value as it was in the read cycle. It is 0 for set/clear-only offsets, for unmapped offsets and whenever bus_rvalid is 0.
- R12: Bits written as 0 to any set or clear register leave those pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| per_a_out | input | 32 | Port A output value per pin |
| per_a_oe | input | 32 | Port A output enable per pin |
| per_b_out | input | 32 | Port B output value per pin |
| per_b_oe | input | 32 | Port B output enable per pin |
| per_c_out | input | 32 | Port C output value per pin |
| per_c_oe | input | 32 | Port C output enable per pin |
| per_d_out | input | 32 | Port D output value per pin |
| per_d_oe | input | 32 | Port D output enable per pin |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Output enable for each pad |
| pad_pu | output | 32 | Pull-up enable per pad |
| pad_pd | output | 32 | Pull-down enable per pad |
| pad_schmitt_dis | output | 32 | Schmitt-trigger disable per pad |

## Verification
Four behaviours are checked by assertions on every cycle:
- the pulls never overlap on a pin;
- a pull-down enable lands on exactly the written pins;
- a zero-valued pull-up enable changes nothing, and the Schmitt register mirrors its write;
- the read-valid timing holds, and general-purpose pins always carry the I/O registers' values.

The selection of one of four ports by a code split across two registers can only be shown by the bench's reference model. The same holds for read-modify-write on one pin leaving its neighbours alone, and for the exact read-back of each register. The model is fed changing peripheral inputs and mixed ownership patterns.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [1:0] {
    FN_A = 2'd0,
    FN_B = 2'd1,
    FN_C = 2'd2,
    FN_D = 2'd3
  } fn_code_e;

  localparam int OFS_W = 9;

  localparam logic [OFS_W-1:0] OFS_OWN_SET  = 9'h000;
  localparam logic [OFS_W-1:0] OFS_OWN_CLR  = 9'h004;
  localparam logic [OFS_W-1:0] OFS_OWN_STS  = 9'h008;
  localparam logic [OFS_W-1:0] OFS_DIR_SET  = 9'h010;
  localparam logic [OFS_W-1:0] OFS_DIR_CLR  = 9'h014;
  localparam logic [OFS_W-1:0] OFS_DIR_STS  = 9'h018;
  localparam logic [OFS_W-1:0] OFS_DAT_SET  = 9'h030;
  localparam logic [OFS_W-1:0] OFS_DAT_CLR  = 9'h034;
  localparam logic [OFS_W-1:0] OFS_DAT_STS  = 9'h038;
  localparam logic [OFS_W-1:0] OFS_PU_CLR   = 9'h060;
  localparam logic [OFS_W-1:0] OFS_PU_SET   = 9'h064;
  localparam logic [OFS_W-1:0] OFS_PU_STS   = 9'h068;
  localparam logic [OFS_W-1:0] OFS_SEL_LO   = 9'h070;
  localparam logic [OFS_W-1:0] OFS_SEL_HI   = 9'h074;
  localparam logic [OFS_W-1:0] OFS_PD_CLR   = 9'h090;
  localparam logic [OFS_W-1:0] OFS_PD_SET   = 9'h094;
  localparam logic [OFS_W-1:0] OFS_PD_STS   = 9'h098;
  localparam logic [OFS_W-1:0] OFS_SCHMITT  = 9'h100;

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  output logic [NPINS-1:0] own_gpio,
  output logic [NPINS-1:0] gpio_dout,
  output logic [NPINS-1:0] gpio_dir,
  output logic [NPINS-1:0] sel_lo,
  output logic [NPINS-1:0] sel_hi,
  output logic [NPINS-1:0] pull_up,
  output logic [NPINS-1:0] pull_dn,
  output logic [NPINS-1:0] st_dis
);

  logic [NPINS-1:0] wbits;
  logic [DW-1:0]    rd_val;

  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_gpio  <= '1;
      gpio_dout <= '0;
      gpio_dir  <= '0;
      sel_lo    <= '0;
      sel_hi    <= '0;
      pull_up   <= '1;
      pull_dn   <= '0;
      st_dis    <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(OFS_OWN_SET): own_gpio  <= own_gpio | wbits;
        AW'(OFS_OWN_CLR): own_gpio  <= own_gpio & ~wbits;
        AW'(OFS_DIR_SET): gpio_dir  <= gpio_dir | wbits;
        AW'(OFS_DIR_CLR): gpio_dir  <= gpio_dir & ~wbits;
        AW'(OFS_DAT_SET): gpio_dout <= gpio_dout | wbits;
        AW'(OFS_DAT_CLR): gpio_dout <= gpio_dout & ~wbits;
        AW'(OFS_PU_CLR):  pull_up   <= pull_up & ~wbits;
        AW'(OFS_PU_SET): begin
          pull_up <= pull_up | wbits;
          pull_dn <= pull_dn & ~wbits;
        end
        AW'(OFS_PD_CLR):  pull_dn   <= pull_dn & ~wbits;
        AW'(OFS_PD_SET): begin
          pull_dn <= pull_dn | wbits;
          pull_up <= pull_up & ~wbits;
        end
        AW'(OFS_SEL_LO):  sel_lo    <= wbits;
        AW'(OFS_SEL_HI):  sel_hi    <= wbits;
        AW'(OFS_SCHMITT): st_dis    <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      AW'(OFS_OWN_STS): rd_val = DW'(own_gpio);
      AW'(OFS_DIR_STS): rd_val = DW'(gpio_dir);
      AW'(OFS_DAT_STS): rd_val = DW'(gpio_dout);
      AW'(OFS_PU_STS):  rd_val = DW'(pull_up);
      AW'(OFS_PD_STS):  rd_val = DW'(pull_dn);
      AW'(OFS_SEL_LO):  rd_val = DW'(sel_lo);
      AW'(OFS_SEL_HI):  rd_val = DW'(sel_hi);
      AW'(OFS_SCHMITT): rd_val = DW'(st_dis);
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_val : '0;
    end
  end

endmodule

// File: rtl/pinmux_fn_sel.sv
module pinmux_fn_sel
  import pinmux_pkg::*;
#(
  parameter int NFN = 4
) (
  input  logic           own_gpio,
  input  logic [1:0]     code,
  input  logic [NFN-1:0] fn_out,
  input  logic [NFN-1:0] fn_oe,
  input  logic           gpio_out,
  input  logic           gpio_oe,
  output logic           pin_out,
  output logic           pin_oe
);

  fn_code_e sel;
  logic     per_o;
  logic     per_e;

  assign sel = fn_code_e'(code);

  always_comb begin
    unique case (sel)
      FN_A: begin per_o = fn_out[0]; per_e = fn_oe[0]; end
      FN_B: begin per_o = fn_out[1]; per_e = fn_oe[1]; end
      FN_C: begin per_o = fn_out[2]; per_e = fn_oe[2]; end
      default: begin per_o = fn_out[3]; per_e = fn_oe[3]; end
    endcase
  end

  assign pin_out = own_gpio ? gpio_out : per_o;
  assign pin_oe  = own_gpio ? gpio_oe  : per_e;

endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own_gpio,
  input  logic [NPINS-1:0] sel_lo,
  input  logic [NPINS-1:0] sel_hi,
  input  logic [NPINS-1:0] gpio_dout,
  input  logic [NPINS-1:0] gpio_dir,
  input  logic [NPINS-1:0] per_a_out,
  input  logic [NPINS-1:0] per_a_oe,
  input  logic [NPINS-1:0] per_b_out,
  input  logic [NPINS-1:0] per_b_oe,
  input  logic [NPINS-1:0] per_c_out,
  input  logic [NPINS-1:0] per_c_oe,
  input  logic [NPINS-1:0] per_d_out,
  input  logic [NPINS-1:0] per_d_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);

  localparam int NFN = 4;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [NFN-1:0] fo;
    logic [NFN-1:0] fe;
    assign fo = {per_d_out[p], per_c_out[p], per_b_out[p], per_a_out[p]};
    assign fe = {per_d_oe[p],  per_c_oe[p],  per_b_oe[p],  per_a_oe[p]};

    pinmux_fn_sel #(.NFN(NFN)) u_sel (
      .own_gpio (own_gpio[p]),
      .code     ({sel_hi[p], sel_lo[p]}),
      .fn_out   (fo),
      .fn_oe    (fe),
      .gpio_out (gpio_dout[p]),
      .gpio_oe  (gpio_dir[p]),
      .pin_out  (pad_out[p]),
      .pin_oe   (pad_oe[p])
    );
  end

endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] per_a_out,
  input  logic [NPINS-1:0] per_a_oe,
  input  logic [NPINS-1:0] per_b_out,
  input  logic [NPINS-1:0] per_b_oe,
  input  logic [NPINS-1:0] per_c_out,
  input  logic [NPINS-1:0] per_c_oe,
  input  logic [NPINS-1:0] per_d_out,
  input  logic [NPINS-1:0] per_d_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_schmitt_dis
);

  logic [NPINS-1:0] own_gpio;
  logic [NPINS-1:0] gpio_dout;
  logic [NPINS-1:0] gpio_dir;
  logic [NPINS-1:0] sel_lo;
  logic [NPINS-1:0] sel_hi;

  pinmux_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .own_gpio   (own_gpio),
    .gpio_dout  (gpio_dout),
    .gpio_dir   (gpio_dir),
    .sel_lo     (sel_lo),
    .sel_hi     (sel_hi),
    .pull_up    (pad_pu),
    .pull_dn    (pad_pd),
    .st_dis     (pad_schmitt_dis)
  );

  pinmux_route #(.NPINS(NPINS)) u_route (
    .own_gpio  (own_gpio),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .gpio_dout (gpio_dout),
    .gpio_dir  (gpio_dir),
    .per_a_out (per_a_out),
    .per_a_oe  (per_a_oe),
    .per_b_out (per_b_out),
    .per_b_oe  (per_b_oe),
    .per_c_out (per_c_out),
    .per_c_oe  (per_c_oe),
    .per_d_out (per_d_out),
    .per_d_oe  (per_d_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_rvalid,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_pd,
  input logic [NPINS-1:0] pad_schmitt_dis,
  input logic [NPINS-1:0] own_gpio,
  input logic [NPINS-1:0] gpio_dout,
  input logic [NPINS-1:0] gpio_dir
);

  // R9
  pulls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  // R8
  pd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_PD_SET)) |=>
      (((pad_pd & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))
       && ((pad_pu & $past(bus_wdata[NPINS-1:0])) == '0)));

  // R12
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_PU_SET) && bus_wdata[NPINS-1:0] == '0) |=>
      ($stable(pad_pu) && $stable(pad_pd)));

  // R10
  schmitt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_SCHMITT)) |=>
      (pad_schmitt_dis == $past(bus_wdata[NPINS-1:0])));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

  // R5
  gpio_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & own_gpio) == (gpio_dout & own_gpio))
    && ((pad_oe & own_gpio) == (gpio_dir & own_gpio)));

endmodule

bind pinmux_bank pinmux_bank_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_pinmux_bank.sv
`timescale 1ns/1ps
module sim_pinmux_bank;

  localparam int NP = 32;
  localparam int DW = 32;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pa_o = '0, pa_e = '0, pb_o = '0, pb_e = '0;
  logic [NP-1:0] pc_o = '0, pc_e = '0, pd_o = '0, pd_e = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pinmux_bank #(.NPINS(NP), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid),
    .per_a_out(pa_o), .per_a_oe(pa_e), .per_b_out(pb_o), .per_b_oe(pb_e),
    .per_c_out(pc_o), .per_c_oe(pc_e), .per_d_out(pd_o), .per_d_oe(pd_e),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_schmitt_dis(pad_st)
  );

  // reference model state
  logic [31:0] m_own, m_dir, m_dat, m_pu, m_pd, m_s1, m_s2, m_st;
  logic [31:0] e_rdata;
  logic        e_rvalid;

  task automatic m_reset();
    m_own = '1; m_dir = '0; m_dat = '0; m_pu = '1; m_pd = '0;
    m_s1 = '0; m_s2 = '0; m_st = '0; e_rdata = '0; e_rvalid = 0;
  endtask

  function automatic logic [31:0] m_read(input int a);
    case (a)
      'h008: return m_own;
      'h018: return m_dir;
      'h038: return m_dat;
      'h068: return m_pu;
      'h098: return m_pd;
      'h070: return m_s1;
      'h074: return m_s2;
      'h100: return m_st;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [31:0] d);
    case (a)
      'h000: m_own = m_own | d;
      'h004: m_own = m_own & ~d;
      'h010: m_dir = m_dir | d;
      'h014: m_dir = m_dir & ~d;
      'h030: m_dat = m_dat | d;
      'h034: m_dat = m_dat & ~d;
      'h060: m_pu = m_pu & ~d;
      'h064: begin m_pu = m_pu | d; m_pd = m_pd & ~d; end
      'h090: m_pd = m_pd & ~d;
      'h094: begin m_pd = m_pd | d; m_pu = m_pu & ~d; end
      'h070: m_s1 = d;
      'h074: m_s2 = d;
      'h100: m_st = d;
      default: ;
    endcase
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] eo, ee;
    for (int i = 0; i < NP; i++) begin
      if (m_own[i]) begin
        eo[i] = m_dat[i]; ee[i] = m_dir[i];
      end else begin
        case ({m_s2[i], m_s1[i]})
          2'd0: begin eo[i] = pa_o[i]; ee[i] = pa_e[i]; end
          2'd1: begin eo[i] = pb_o[i]; ee[i] = pb_e[i]; end
          2'd2: begin eo[i] = pc_o[i]; ee[i] = pc_e[i]; end
          default: begin eo[i] = pd_o[i]; ee[i] = pd_e[i]; end
        endcase
      end
    end
    cmp("R4,R5 pad_out", pad_out, eo);
    cmp("R4,R5 pad_oe", pad_oe, ee);
    cmp("R7,R9 pad_pu", pad_pu, m_pu);
    cmp("R8,R9 pad_pd", pad_pd, m_pd);
    cmp("R10 pad_schmitt_dis", pad_st, m_st);
    cmp("R11 bus_rvalid", {31'h0, bus_rvalid}, {31'h0, e_rvalid});
    cmp("R11 bus_rdata", bus_rdata, e_rdata);
  endtask

  // one bus cycle: drive after a falling edge, check at the next falling edge
  task automatic cyc(input bit w, input bit r, input int a, input logic [31:0] d);
    bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = d;
    e_rvalid = r;
    e_rdata = r ? m_read(a) : 32'h0;
    if (w) m_write(a, d);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic rd(input int a);
    cyc(0, 1, a, 32'h0);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 32'h0);
  endtask

  task automatic shake_ports();
    pa_o = $urandom; pa_e = $urandom; pb_o = $urandom; pb_e = $urandom;
    pc_o = $urandom; pc_e = $urandom; pd_o = $urandom; pd_e = $urandom;
  endtask

  function automatic void summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  int addrs [16] = '{'h000, 'h004, 'h008, 'h010, 'h014, 'h030, 'h034, 'h060,
                     'h064, 'h070, 'h074, 'h090, 'h094, 'h098, 'h100, 'h0c0};

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the pads and through read-back
    check_all();
    rd('h008); rd('h068); rd('h098); rd('h070); rd('h074); rd('h100);
    rd('h018); rd('h038);

    // R6: direction and data through general-purpose ownership (R5)
    wr('h010, 32'hF0F0_1234); wr('h030, 32'h0FF0_00FF); rd('h018); rd('h038);
    wr('h034, 32'h0000_000F); rd('h038);
    // R12: zero writes change nothing
    wr('h010, 32'h0); wr('h014, 32'h0); wr('h000, 32'h0); wr('h004, 32'h0);
    wr('h064, 32'h0); wr('h094, 32'h0); rd('h018); rd('h068);

    // R3: select codes, pins cycle through A..D
    wr('h070, 32'hAAAA_AAAA); wr('h074, 32'hCCCC_CCCC); rd('h070); rd('h074);
    // R5: select code ignored while pins remain general-purpose
    shake_ports(); idle(); idle();
    // R2: hand half the pins to peripherals
    wr('h004, 32'hFFFF_0000); rd('h008);
    // R4: each code sees its own port under several input patterns
    for (int k = 0; k < 8; k++) begin shake_ports(); idle(); end
    pa_o = '1; pb_o = '0; pc_o = '1; pd_o = '0; pa_e = '0; pb_e = '1; pc_e = '0; pd_e = '1;
    idle();
    // R3: read-modify-write of one pin's low code bit
    rd('h070);
    wr('h070, m_s1 ^ 32'h0001_0000);
    rd('h070);
    shake_ports(); idle();
    // R2: return a few pins, take all the rest
    wr('h000, 32'h0003_0000); wr('h004, 32'h0000_FFFF); rd('h008);
    shake_ports(); idle();

    // R7, R8, R9: pull interplay
    wr('h094, 32'h0000_00FF); rd('h068); rd('h098);
    wr('h064, 32'h0000_000F); rd('h068); rd('h098);
    wr('h060, 32'hFFFF_0000); wr('h090, 32'h0000_0030); rd('h068); rd('h098);

    // R10: Schmitt register
    wr('h100, 32'hDEAD_BEEF); rd('h100); wr('h100, 32'h0000_0001); rd('h100);

    // R11: set/clear-only and unmapped offsets read 0; read and write together
    rd('h000); rd('h094); rd('h0C0); rd('h1FC);
    cyc(1, 1, 'h070, 32'h1234_5678); rd('h070);

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      int sel;
      logic [31:0] d;
      sel = $urandom_range(0, 15);
      d = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom;
      if ($urandom_range(0, 3) == 0) shake_ports();
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, addrs[sel], d);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule